// File: doc/BRIEF.md
# Exception Stacking Sequencer

This block is the hardware state machine that a small processor core uses to enter and leave exceptions. When an exception is accepted, it selects the active stack pointer and writes the eight-word caller context frame to memory through a word-wide request/ready port. It then reads the handler address from a vector table whose base can be relocated. Finally it records the exception number, which moves the core into handler mode. On an exception-return request it reads the frame back, hands each word to the core's register file, and restores the previous exception number.

After reset the sequencer fetches the initial main stack pointer and the reset handler address from the first two vector-table words before it accepts any work. The core stays stalled while `busy` is high. It must hold the context register inputs stable for the whole of an entry sequence. A push that would cross the configured stack limit is refused before any memory access, and a fault flag is raised instead.

Top module: `exc_stack_seq`

## Requirements
- R1: After reset the block reads the word at the vector base (parameter `VT_RESET`, default 0) into the main stack pointer, then the word at base+4 onto `pc_target` with a one-cycle `pc_load` pulse. During this it holds `busy` high, with exception number 0 and thread mode.
- R2: An entry request is taken only when the block is idle and `exc_num` is nonzero. A request carrying number 0, or any request raised while busy, causes no memory access and no change of state.
- R3: In thread mode an entry pushes onto the process stack pointer when `thread_spsel` is 1 and onto the main stack pointer when it is 0. In handler mode an entry always pushes onto the main stack pointer.
- R4: An entry writes eight words at SP−4 down to SP−32 in strictly descending address order. Word k sits at SP−32+4k, with k = 0..7 holding R0, R1, R2, R3, R12, LR, PC and the status word. The status word is written with its low `NUM_W` bits replaced by the exception number current before entry. The chosen stack pointer then becomes SP−32.
- R5: After the push, the block reads the word at base + 4 × number and presents it on `pc_target` with a one-cycle `pc_load` pulse. In the same cycle `exc_active` takes the new number.
- R6: `handler_mode` is high exactly when `exc_active` is nonzero. `priv` is 1 in handler mode and equals the inverse of `thread_unpriv` in thread mode.
- R7: A `vt_wr` pulse while idle replaces the vector base, and every later vector fetch uses the new base.
- R8: If SP < 32 or SP−32 is below `stk_limit`, the entry is aborted with no memory access and no change to the stack pointers or exception number, and `ovf_fault` is set. The next successful entry clears `ovf_fault`.
- R9: A return request in handler mode reads eight words at ascending addresses from the stack named by `ret_psp` (1 = process, 0 = main). Each word is presented on `rf_wdata` with `rf_we` and `rf_idx` = k, using the same index meaning as R4. That stack pointer then becomes SP+32, and `exc_active` is restored from the low `NUM_W` bits of the status word read back.
- R10: A return request in thread mode is ignored. When an entry request and a return request arrive together, the entry wins.
- R11: An unanswered memory request keeps its address and write flag until `mem_ready`. `busy` is high for every sequence and low when idle.
- R12: A `psp_load` pulse while idle sets the process stack pointer to `psp_load_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| exc_req | input | 1 | Exception entry request |
| exc_num | input | NUM_W | Number of the requested exception |
| ret_req | input | 1 | Exception return request |
| ret_psp | input | 1 | Return pops from the process stack when 1 |
| thread_spsel | input | 1 | Thread-mode stack select (1 = process stack) |
| thread_unpriv | input | 1 | Thread mode runs unprivileged when 1 |
| ctx_r0 | input | 32 | Context register R0 |
| ctx_r1 | input | 32 | Context register R1 |
| ctx_r2 | input | 32 | Context register R2 |
| ctx_r3 | input | 32 | Context register R3 |
| ctx_r12 | input | 32 | Context register R12 |
| ctx_lr | input | 32 | Link register |
| ctx_pc | input | 32 | Return program counter |
| ctx_psr | input | 32 | Status word |
| stk_limit | input | 32 | Lowest address a push may write |
| psp_load | input | 1 | Load the process stack pointer |
| psp_load_val | input | 32 | Value for the process stack pointer |
| vt_wr | input | 1 | Write the vector base |
| vt_wdata | input | 32 | New vector base |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ready |
| mem_ready | input | 1 | Memory completes the request this cycle |
| busy | output | 1 | A sequence is in progress |
| handler_mode | output | 1 | Core is in handler mode |
| priv | output | 1 | Core is privileged |
| exc_active | output | NUM_W | Active exception number (0 in thread mode) |
| msp_o | output | 32 | Main stack pointer |
| psp_o | output | 32 | Process stack pointer |
| pc_load | output | 1 | One-cycle pulse: load `pc_target` |
| pc_target | output | 32 | Handler or reset address |
| rf_we | output | 1 | Restore one register |
| rf_idx | output | 3 | Index of the register being restored |
| rf_wdata | output | 32 | Restored value |
| ovf_fault | output | 1 | Last entry aborted on stack limit |

## Verification
The bench builds the block with `NUM_W` = 6 and the reset vector base at 0. The bench memory model is 256 words, so every vector, frame and stack address can be predicted exactly. It sweeps memory wait states 0 to 2 against both thread stack selections and several exception numbers on both sides of the relocated table. For each case it checks the pushed frame word by word, the write ordering and the popped sequence against arithmetic expectations. Directed cases then cover nesting from handler mode, the overflow limit (including a stack pointer below 32), ignored requests and the entry-over-return priority.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned FRAME_WORDS = 8;
    localparam int unsigned FRAME_BYTES = FRAME_WORDS * (WORD_W / 8);
    localparam int unsigned IDX_W       = $clog2(FRAME_WORDS);

    typedef enum logic [2:0] {
        ST_BOOT_SP,
        ST_BOOT_PC,
        ST_IDLE,
        ST_PUSH,
        ST_VEC,
        ST_POP
    } seq_state_e;

    // Slot order: r0, r1, r2, r3, r12, lr, pc, status (slot k at base + 4k)
    typedef logic [FRAME_WORDS-1:0][WORD_W-1:0] frame_t;

endpackage

// File: rtl/exc_sp_calc.sv
module exc_sp_calc #(
    parameter int unsigned W  = 32,
    parameter int unsigned FB = 32
) (
    input  logic [W-1:0] msp_i,
    input  logic [W-1:0] psp_i,
    input  logic         thread_i,
    input  logic         spsel_i,
    input  logic         ret_i,
    input  logic         ret_psp_i,
    input  logic [W-1:0] limit_i,
    output logic         use_psp_o,
    output logic [W-1:0] sp_o,
    output logic [W-1:0] push_base_o,
    output logic         ovf_o
);

    localparam logic [W-1:0] FRAME_SZ = W'(FB);

    always_comb begin
        // a return names its stack; an entry from handler mode always uses main
        use_psp_o   = ret_i ? ret_psp_i : (thread_i & spsel_i);
        sp_o        = use_psp_o ? psp_i : msp_i;
        push_base_o = sp_o - FRAME_SZ;
        ovf_o       = (sp_o < FRAME_SZ) || (push_base_o < limit_i);
    end

endmodule

// File: rtl/exc_frame_mux.sv
module exc_frame_mux
    import exc_seq_pkg::*;
(
    input  frame_t             frame_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [WORD_W-1:0]  word_o
);

    logic [FRAME_WORDS-1:0][WORD_W-1:0] slot_masked;

    for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_slot
        assign slot_masked[g] = (idx_i == IDX_W'(g)) ? frame_i[g] : '0;
    end

    always_comb begin
        word_o = '0;
        for (int k = 0; k < FRAME_WORDS; k++) begin
            word_o = word_o | slot_masked[k];
        end
    end

endmodule

// File: rtl/exc_stack_seq.sv
module exc_stack_seq
    import exc_seq_pkg::*;
#(
    parameter int unsigned NUM_W    = 6,
    parameter logic [31:0] VT_RESET = 32'h0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic [NUM_W-1:0] exc_num,
    input  logic             ret_req,
    input  logic             ret_psp,
    input  logic             thread_spsel,
    input  logic             thread_unpriv,
    input  logic [31:0]      ctx_r0,
    input  logic [31:0]      ctx_r1,
    input  logic [31:0]      ctx_r2,
    input  logic [31:0]      ctx_r3,
    input  logic [31:0]      ctx_r12,
    input  logic [31:0]      ctx_lr,
    input  logic [31:0]      ctx_pc,
    input  logic [31:0]      ctx_psr,
    input  logic [31:0]      stk_limit,
    input  logic             psp_load,
    input  logic [31:0]      psp_load_val,
    input  logic             vt_wr,
    input  logic [31:0]      vt_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ready,
    output logic             busy,
    output logic             handler_mode,
    output logic             priv,
    output logic [NUM_W-1:0] exc_active,
    output logic [31:0]      msp_o,
    output logic [31:0]      psp_o,
    output logic             pc_load,
    output logic [31:0]      pc_target,
    output logic             rf_we,
    output logic [2:0]       rf_idx,
    output logic [31:0]      rf_wdata,
    output logic             ovf_fault
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);
    localparam logic [31:0]      FRAME_SZ = 32'(FRAME_BYTES);
    localparam logic [31:0]      NUM_MASK = 32'((64'd1 << NUM_W) - 64'd1);

    typedef struct packed {
        seq_state_e        state;
        logic [IDX_W-1:0]  cnt;
        logic [31:0]       msp;
        logic [31:0]       psp;
        logic [31:0]       vtor;
        logic [31:0]       base;
        logic              op_psp;
        logic [NUM_W-1:0]  ipsr;
        logic [NUM_W-1:0]  num;
        logic              ovf;
        logic [31:0]       pc_tgt;
        logic              pc_load;
        logic              rf_we;
        logic [IDX_W-1:0]  rf_idx;
        logic [31:0]       rf_wdata;
    } seq_regs_t;

    seq_regs_t q, d;

    logic        exc_take;
    logic        use_psp;
    logic [31:0] sel_sp;
    logic [31:0] push_base;
    logic        push_ovf;
    frame_t      frame;
    logic [31:0] frame_word;
    logic [31:0] word_off;

    assign exc_take = exc_req && (exc_num != '0);

    exc_sp_calc #(
        .W  (32),
        .FB (FRAME_BYTES)
    ) u_sp_calc (
        .msp_i       (q.msp),
        .psp_i       (q.psp),
        .thread_i    (q.ipsr == '0),
        .spsel_i     (thread_spsel),
        .ret_i       (!exc_take),
        .ret_psp_i   (ret_psp),
        .limit_i     (stk_limit),
        .use_psp_o   (use_psp),
        .sp_o        (sel_sp),
        .push_base_o (push_base),
        .ovf_o       (push_ovf)
    );

    always_comb begin
        frame[0] = ctx_r0;
        frame[1] = ctx_r1;
        frame[2] = ctx_r2;
        frame[3] = ctx_r3;
        frame[4] = ctx_r12;
        frame[5] = ctx_lr;
        frame[6] = ctx_pc;
        frame[7] = (ctx_psr & ~NUM_MASK) | 32'(q.ipsr);
    end

    exc_frame_mux u_frame_mux (
        .frame_i (frame),
        .idx_i   (q.cnt),
        .word_o  (frame_word)
    );

    assign word_off = 32'({q.cnt, 2'b00});

    // next-state process
    always_comb begin
        d         = q;
        d.pc_load = 1'b0;
        d.rf_we   = 1'b0;

        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        unique case (q.state)
            ST_BOOT_SP: begin
                mem_req  = 1'b1;
                mem_addr = q.vtor;
                if (mem_ready) begin
                    d.msp   = mem_rdata;
                    d.state = ST_BOOT_PC;
                end
            end
            ST_BOOT_PC: begin
                mem_req  = 1'b1;
                mem_addr = q.vtor + 32'd4;
                if (mem_ready) begin
                    d.pc_tgt  = mem_rdata;
                    d.pc_load = 1'b1;
                    d.state   = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (exc_take) begin
                    if (push_ovf) begin
                        d.ovf = 1'b1;
                    end else begin
                        d.ovf    = 1'b0;
                        d.state  = ST_PUSH;
                        d.cnt    = LAST_IDX;
                        d.base   = push_base;
                        d.op_psp = use_psp;
                        d.num    = exc_num;
                    end
                end else if (ret_req && (q.ipsr != '0)) begin
                    d.state  = ST_POP;
                    d.cnt    = '0;
                    d.base   = sel_sp;
                    d.op_psp = use_psp;
                end else if (psp_load) begin
                    d.psp = psp_load_val;
                end
                if (vt_wr) begin
                    d.vtor = vt_wdata;
                end
            end
            ST_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.base + word_off;
                mem_wdata = frame_word;
                if (mem_ready) begin
                    if (q.cnt == '0) begin
                        if (q.op_psp) d.psp = q.base;
                        else          d.msp = q.base;
                        d.state = ST_VEC;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            ST_VEC: begin
                mem_req  = 1'b1;
                mem_addr = q.vtor + 32'({q.num, 2'b00});
                if (mem_ready) begin
                    d.pc_tgt  = mem_rdata;
                    d.pc_load = 1'b1;
                    d.ipsr    = q.num;
                    d.state   = ST_IDLE;
                end
            end
            ST_POP: begin
                mem_req  = 1'b1;
                mem_addr = q.base + word_off;
                if (mem_ready) begin
                    d.rf_we    = 1'b1;
                    d.rf_idx   = q.cnt;
                    d.rf_wdata = mem_rdata;
                    if (q.cnt == LAST_IDX) begin
                        d.ipsr = mem_rdata[NUM_W-1:0];
                        if (q.op_psp) d.psp = q.base + FRAME_SZ;
                        else          d.msp = q.base + FRAME_SZ;
                        d.state = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    // register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_BOOT_SP;
            q.vtor     <= VT_RESET;
        end else begin
            q <= d;
        end
    end

    assign busy         = (q.state != ST_IDLE);
    assign handler_mode = (q.ipsr != '0);
    assign priv         = handler_mode | ~thread_unpriv;
    assign exc_active   = q.ipsr;
    assign msp_o        = q.msp;
    assign psp_o        = q.psp;
    assign pc_load      = q.pc_load;
    assign pc_target    = q.pc_tgt;
    assign rf_we        = q.rf_we;
    assign rf_idx       = 3'(q.rf_idx);
    assign rf_wdata     = q.rf_wdata;
    assign ovf_fault    = q.ovf;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11

    AST_NO_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $stable(stk_limit)) |-> (mem_addr >= stk_limit)); // R8

    AST_ENTRY_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(handler_mode) |-> pc_load); // R5

    AST_EXIT_ON_STATUS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(handler_mode) |-> (rf_we && (rf_idx == 3'd7))); // R9

endmodule

// File: tb/exc_stack_seq_bench.sv
module exc_stack_seq_bench;

    localparam int NUM_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             exc_req = 1'b0;
    logic [NUM_W-1:0] exc_num = '0;
    logic             ret_req = 1'b0;
    logic             ret_psp = 1'b0;
    logic             thread_spsel = 1'b0;
    logic             thread_unpriv = 1'b0;
    logic [31:0]      regv [8];
    logic [31:0]      stk_limit = 32'h100;
    logic             psp_load = 1'b0;
    logic [31:0]      psp_load_val = '0;
    logic             vt_wr = 1'b0;
    logic [31:0]      vt_wdata = '0;
    logic             mem_req, mem_we;
    logic [31:0]      mem_addr, mem_wdata;
    logic [31:0]      mem_rdata = '0;
    logic             mem_ready = 1'b0;
    logic             busy, handler_mode, priv;
    logic [NUM_W-1:0] exc_active;
    logic [31:0]      msp_o, psp_o, pc_target, rf_wdata;
    logic             pc_load, rf_we, ovf_fault;
    logic [2:0]       rf_idx;

    always #5 clk = ~clk;

    exc_stack_seq #(.NUM_W(NUM_W), .VT_RESET(32'h0)) u_exc_stack_seq (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_num(exc_num),
        .ret_req(ret_req), .ret_psp(ret_psp), .thread_spsel(thread_spsel),
        .thread_unpriv(thread_unpriv),
        .ctx_r0(regv[0]), .ctx_r1(regv[1]), .ctx_r2(regv[2]), .ctx_r3(regv[3]),
        .ctx_r12(regv[4]), .ctx_lr(regv[5]), .ctx_pc(regv[6]), .ctx_psr(regv[7]),
        .stk_limit(stk_limit), .psp_load(psp_load), .psp_load_val(psp_load_val),
        .vt_wr(vt_wr), .vt_wdata(vt_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .handler_mode(handler_mode), .priv(priv), .exc_active(exc_active),
        .msp_o(msp_o), .psp_o(psp_o), .pc_load(pc_load), .pc_target(pc_target),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata), .ovf_fault(ovf_fault)
    );

    // ---------------- memory model and monitors ----------------
    logic [31:0] mem [256];
    int          wait_states = 0;
    int          wcnt = 0;
    logic [31:0] wr_log [1024];
    int          wr_n = 0;
    logic [2:0]  rf_log_idx [1024];
    logic [31:0] rf_log_dat [1024];
    int          rf_n = 0;
    int          pc_n = 0;
    logic [31:0] last_pc = '0;
    int          busy_cnt = 0;
    int          hold_err = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic        pend_we = 1'b0;

    function automatic logic [31:0] vec(input int idx);
        return 32'h8000_0000 | (32'(idx) << 4) | 32'h1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) mem[k] <= vec(k);
            mem[0] <= 32'h3F0;
        end else if (mem_req && mem_ready && mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            if (wr_n < 1024) wr_log[wr_n] <= mem_addr;
            wr_n <= wr_n + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && pend && (!mem_req || mem_addr != pend_addr || mem_we != pend_we))
            hold_err <= hold_err + 1;
        if (mem_req) begin
            if (wcnt >= wait_states) begin
                mem_ready <= 1'b1;
                mem_rdata <= mem[mem_addr[9:2]];
                wcnt      <= 0;
                pend      <= 1'b0;
            end else begin
                mem_ready <= 1'b0;
                wcnt      <= wcnt + 1;
                pend      <= 1'b1;
                pend_addr <= mem_addr;
                pend_we   <= mem_we;
            end
        end else begin
            mem_ready <= 1'b0;
            wcnt      <= 0;
            pend      <= 1'b0;
        end
        if (rst_n && rf_we) begin
            if (rf_n < 1024) begin
                rf_log_idx[rf_n] <= rf_idx;
                rf_log_dat[rf_n] <= rf_wdata;
            end
            rf_n <= rf_n + 1;
        end
        if (rst_n && pc_load) begin
            pc_n    <= pc_n + 1;
            last_pc <= pc_target;
        end
        if (rst_n && busy) busy_cnt <= busy_cnt + 1;
    end

    // ---------------- checking ----------------
    int n_checks = 0;
    int n_fail = 0;
    logic [31:0]      exp_msp = 32'h3F0;
    logic [31:0]      exp_psp = '0;
    logic [NUM_W-1:0] exp_ipsr = '0;
    logic [31:0]      vt_base = '0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_exc(input logic [NUM_W-1:0] n, input int hold);
        @(negedge clk);
        exc_num = n;
        exc_req = 1'b1;
        repeat (hold) @(negedge clk);
        exc_req = 1'b0;
        wait_idle();
    endtask

    task automatic pulse_ret(input bit use_p);
        @(negedge clk);
        ret_psp = use_p;
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        wait_idle();
    endtask

    task automatic do_psp_load(input logic [31:0] v);
        @(negedge clk);
        psp_load_val = v;
        psp_load = 1'b1;
        @(negedge clk);
        psp_load = 1'b0;
        exp_psp = v;
        chk(psp_o == v, "R12 process sp load", psp_o, v);
    endtask

    function automatic logic [31:0] frame_word(input int k, input logic [NUM_W-1:0] ip);
        if (k == 7) return {regv[7][31:NUM_W], ip};
        return regv[k];
    endfunction

    task automatic do_entry(input logic [NUM_W-1:0] n, input int hold);
        logic [31:0] sp0, a;
        logic [NUM_W-1:0] ip0;
        bit use_p;
        int wb, pb;
        use_p = (exp_ipsr == '0) && thread_spsel;
        sp0 = use_p ? exp_psp : exp_msp;
        ip0 = exp_ipsr;
        wb = wr_n;
        pb = pc_n;
        pulse_exc(n, hold);
        chk(wr_n - wb == 8, "R4 frame word count", 32'(wr_n - wb), 32'd8);
        for (int j = 0; j < 8; j++)
            chk(wr_log[wb + j] == sp0 - 32'(4 + 4 * j), "R4 descending write order",
                wr_log[wb + j], sp0 - 32'(4 + 4 * j));
        for (int k = 0; k < 8; k++) begin
            a = sp0 - 32 + 32'(4 * k);
            chk(mem[a[9:2]] == frame_word(k, ip0), "R4 frame slot contents",
                mem[a[9:2]], frame_word(k, ip0));
        end
        if (use_p) exp_psp = sp0 - 32;
        else       exp_msp = sp0 - 32;
        chk(msp_o == exp_msp, "R3 main sp after entry", msp_o, exp_msp);
        chk(psp_o == exp_psp, "R3 process sp after entry", psp_o, exp_psp);
        chk(pc_n - pb == 1, "R5 single pc_load", 32'(pc_n - pb), 32'd1);
        chk(last_pc == vec(int'(vt_base >> 2) + int'(n)), "R5 handler address",
            last_pc, vec(int'(vt_base >> 2) + int'(n)));
        exp_ipsr = n;
        chk(exc_active == n, "R5 active number", 32'(exc_active), 32'(n));
        chk(handler_mode == 1'b1, "R6 handler mode", 32'(handler_mode), 32'd1);
        chk(priv == 1'b1, "R6 handler privileged", 32'(priv), 32'd1);
        chk(busy == 1'b0, "R11 idle after entry", 32'(busy), 32'd0);
        chk(ovf_fault == 1'b0, "R8 flag clear on good entry", 32'(ovf_fault), 32'd0);
    endtask

    task automatic do_return(input bit use_p);
        logic [31:0] sp0, a, st;
        int rb;
        sp0 = use_p ? exp_psp : exp_msp;
        rb = rf_n;
        pulse_ret(use_p);
        chk(rf_n - rb == 8, "R9 pop count", 32'(rf_n - rb), 32'd8);
        for (int j = 0; j < 8; j++) begin
            a = sp0 + 32'(4 * j);
            chk(rf_log_idx[rb + j] == 3'(j), "R9 restore index order",
                32'(rf_log_idx[rb + j]), 32'(j));
            chk(rf_log_dat[rb + j] == mem[a[9:2]], "R9 restored word",
                rf_log_dat[rb + j], mem[a[9:2]]);
        end
        a = sp0 + 28;
        st = mem[a[9:2]];
        exp_ipsr = st[NUM_W-1:0];
        if (use_p) exp_psp = sp0 + 32;
        else       exp_msp = sp0 + 32;
        chk(msp_o == exp_msp, "R9 main sp after return", msp_o, exp_msp);
        chk(psp_o == exp_psp, "R9 process sp after return", psp_o, exp_psp);
        chk(exc_active == exp_ipsr, "R9 number restored", 32'(exc_active), 32'(exp_ipsr));
        chk(handler_mode == (exp_ipsr != '0), "R6 mode follows number",
            32'(handler_mode), 32'(exp_ipsr != '0));
        chk(priv == ((exp_ipsr != '0) | ~thread_unpriv), "R6 privilege",
            32'(priv), 32'((exp_ipsr != '0) | ~thread_unpriv));
    endtask

    task automatic set_regs(input int seed);
        for (int k = 0; k < 7; k++) regv[k] = 32'h1000_0000 * 32'(k + 1) + 32'(seed * 97 + k);
        regv[7] = 32'h2100_0000 | 32'(seed * 13);
    endtask

    function automatic logic [NUM_W-1:0] pick_num(input int i);
        case (i)
            0: return 6'd2;
            1: return 6'd9;
            2: return 6'd31;
            default: return 6'd55;
        endcase
    endfunction

    task automatic run_all();
        int wb, rb, bc;
        logic [31:0] m0, p0;
        set_regs(1);
        // R1 reset behaviour
        repeat (2) @(negedge clk);
        chk(busy == 1'b1, "R1 busy during reset", 32'(busy), 32'd1);
        chk(handler_mode == 1'b0, "R1 thread mode at reset", 32'(handler_mode), 32'd0);
        rst_n = 1'b1;
        wait_idle();
        chk(msp_o == 32'h3F0, "R1 initial main sp", msp_o, 32'h3F0);
        chk(pc_n == 1 && last_pc == vec(1), "R1 reset handler", last_pc, vec(1));
        chk(exc_active == '0, "R1 number zero", 32'(exc_active), 32'd0);

        // entry at reset base, then relocation (R7)
        do_entry(6'd3, 1);
        do_return(1'b0);
        @(negedge clk);
        vt_wdata = 32'h200;
        vt_wr = 1'b1;
        @(negedge clk);
        vt_wr = 1'b0;
        vt_base = 32'h200;
        thread_spsel = 1'b0;
        do_entry(6'd3, 1);
        chk(last_pc == vec(128 + 3), "R7 relocated vector", last_pc, vec(131));
        do_return(1'b0);

        // sweep: wait states x stack select x exception number
        for (int ws = 0; ws < 3; ws++) begin
            for (int sel = 0; sel < 2; sel++) begin
                for (int ni = 0; ni < 4; ni++) begin
                    wait_states = ws;
                    thread_spsel = sel[0];
                    thread_unpriv = ni[0];
                    set_regs(ws * 8 + sel * 4 + ni + 2);
                    do_psp_load(32'h3A0);
                    do_entry(pick_num(ni), 1);
                    do_return(sel[0]);
                end
            end
        end

        // nesting: thread on process stack, then second entry from handler mode (R3)
        wait_states = 1;
        thread_spsel = 1'b1;
        thread_unpriv = 1'b1;
        set_regs(40);
        do_entry(6'd5, 1);
        set_regs(41);
        m0 = exp_msp;
        do_entry(6'd7, 1);
        chk(msp_o == m0 - 32, "R3 handler entry uses main sp", msp_o, m0 - 32);
        do_return(1'b0);
        chk(exc_active == 6'd5, "R9 nested number restored", 32'(exc_active), 32'd5);
        do_return(1'b1);
        chk(priv == 1'b0, "R6 unprivileged thread", 32'(priv), 32'd0);

        // R2: number zero ignored
        wb = wr_n;
        bc = busy_cnt;
        pulse_exc(6'd0, 1);
        chk(wr_n == wb && busy_cnt == bc, "R2 number zero ignored", 32'(wr_n - wb), 32'd0);
        chk(exc_active == '0, "R2 state unchanged", 32'(exc_active), 32'd0);

        // R2: request held while busy is not taken twice
        wait_states = 2;
        thread_spsel = 1'b0;
        do_entry(6'd12, 4);
        do_return(1'b0);

        // R10: return in thread mode ignored
        rb = rf_n;
        bc = busy_cnt;
        pulse_ret(1'b0);
        chk(rf_n == rb && busy_cnt == bc, "R10 thread return ignored", 32'(rf_n - rb), 32'd0);

        // R10: entry wins over simultaneous return
        do_entry(6'd4, 1);
        rb = rf_n;
        wb = wr_n;
        @(negedge clk);
        exc_num = 6'd8;
        exc_req = 1'b1;
        ret_req = 1'b1;
        ret_psp = 1'b0;
        @(negedge clk);
        exc_req = 1'b0;
        ret_req = 1'b0;
        wait_idle();
        chk(wr_n - wb == 8 && rf_n == rb, "R10 entry has priority", 32'(wr_n - wb), 32'd8);
        chk(exc_active == 6'd8, "R10 entered number", 32'(exc_active), 32'd8);
        exp_msp = exp_msp - 32;
        exp_ipsr = 6'd8;
        do_return(1'b0);
        do_return(1'b0);

        // R8: overflow against limit
        m0 = msp_o;
        p0 = psp_o;
        stk_limit = m0 - 16;
        wb = wr_n;
        bc = busy_cnt;
        pulse_exc(6'd6, 1);
        chk(ovf_fault == 1'b1, "R8 overflow flag", 32'(ovf_fault), 32'd1);
        chk(wr_n == wb && busy_cnt == bc, "R8 no access on overflow", 32'(wr_n - wb), 32'd0);
        chk(msp_o == m0 && psp_o == p0, "R8 stack pointers kept", msp_o, m0);
        chk(exc_active == '0, "R8 number kept", 32'(exc_active), 32'd0);
        stk_limit = 32'h100;
        do_entry(6'd6, 1);
        do_return(1'b0);

        // R8: stack pointer below one frame
        stk_limit = 32'h0;
        thread_spsel = 1'b1;
        do_psp_load(32'h10);
        wb = wr_n;
        pulse_exc(6'd6, 1);
        chk(ovf_fault == 1'b1 && wr_n == wb, "R8 wrap below zero", 32'(ovf_fault), 32'd1);
        chk(psp_o == 32'h10, "R8 process sp kept", psp_o, 32'h10);

        chk(hold_err == 0, "R11 request held until ready", 32'(hold_err), 32'd0);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) chk(1'b0, "R11 watchdog expired", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule